// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

An 8-bit up-counter is driven from a timebase that is one quarter of the core clock. A 2-bit field selects a further prescale ratio of 1, 4 or 16. On every timer tick the count is compared with a period register. When the two are equal, the count restarts from zero, a one-cycle match pulse is produced, and a 4-bit postscaler advances. The postscaler sets a sticky interrupt flag once every 1 to 16 matches. The match pulse can serve as the shift clock of a neighbouring serial block.

Software sees four byte-wide registers behind a small write/read port: the count, the period, a control byte and the flag. Writing the count or the control byte restarts the prescale chain and the postscaler. A control write leaves the count untouched, so the timer can be reconfigured or paused in mid-period.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control byte reads 00h, the flag reads 0, and irq_o and match_o are low.
- R2: Register addresses are: 0 = count, 1 = period, 2 = control, 3 = flag (bit 0). The control byte layout is: bits 1:0 prescale select, bit 2 enable, bits 6:3 postscale select. Bit 7 always reads 0. The count, the period and control bits 6:0 read back the value written.
- R3: While enabled, the timer ticks once every 4*K core cycles, where K is 1 for prescale select 00, 4 for 01, and 16 for 10 or 11. The first tick comes 4*K cycles after the clock edge of the enabling control write.
- R4: On each tick the count increments. If the count equals the period on a tick, the count becomes 00h instead, and match_o is high for the one cycle that follows. A period P therefore gives one match every P+1 ticks, and this includes P = 0.
- R5: With postscale select N, the flag is set on every (N+1)-th match, in the same cycle that match_o shows that match. irq_o follows the flag.
- R6: Writing address 3 with bit 0 = 1 clears the flag. A flag set in the same cycle wins.
- R7: A write to the count or to the control byte clears the quarter-rate divider, the prescaler and the postscaler. Counting then resumes a full 4*K cycles later, and the next postscale period starts from zero.
- R8: A write to the control byte does not change the count.
- R9: A count write is visible from the next cycle. It takes priority over an increment or match restart in the same cycle, and no match pulse results from that cycle.
- R10: While the enable bit is 0, the count, the prescaler and the postscaler hold and no match pulse occurs. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i (combinational) |
| match_o | output | 1 | One-cycle pulse per period match |
| irq_o | output | 1 | Sticky postscaled interrupt flag |

## Verification
The bench predicts the exact cycle of every match pulse and every flag rise. It does this for each prescale encoding, including the don't-care bit and a zero period. An off-by-one in the period, the quarter-rate divider or the prescale limit therefore shows up as a mistimed pulse. A mid-period count write must both restart the prescale chain and reset the postscaler: a design that keeps the old postscale count raises the flag one match early. The bench reads the count around a control write to catch a design that clears the count or skips the prescale restart. It also reads the count over a long disabled stretch to catch a timer that keeps running.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned PRE_CNT_W = 4;
  localparam int unsigned POST_W    = 4;

  typedef enum logic [1:0] {
    REG_CNT = 2'd0,
    REG_PER = 2'd1,
    REG_CTL = 2'd2,
    REG_FLG = 2'd3
  } reg_addr_e;

  // packed order matches control byte bits 6:0
  typedef struct packed {
    logic [POST_W-1:0] post_sel;
    logic              run;
    logic [1:0]        pre_sel;
  } ctl_t;

  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = PRE_CNT_W'(0);
      2'b01:   pre_limit = PRE_CNT_W'(3);
      default: pre_limit = PRE_CNT_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import ptmr_pkg::*;

  logic                 base_tick;
  logic [PRE_CNT_W-1:0] pre_q;
  logic                 pre_hit;

  generate
    if (BASE_DIV > 1) begin : g_div
      localparam int unsigned PH_W = $clog2(BASE_DIV);
      logic [PH_W-1:0] ph_q;
      assign base_tick = (ph_q == PH_W'(BASE_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ph_q <= '0;
        else if (clr_i)   ph_q <= '0;
        else if (run_i)   ph_q <= base_tick ? '0 : ph_q + 1'b1;
      end
    end else begin : g_nodiv
      assign base_tick = 1'b1;
    end
  endgenerate

  assign pre_hit = (pre_q == pre_limit(sel_i));
  assign tick_o  = run_i && !clr_i && base_tick && pre_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pre_q <= '0;
    else if (clr_i)                  pre_q <= '0;
    else if (run_i && base_tick)     pre_q <= pre_hit ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        step_i,
  input  logic [ptmr_pkg::POST_W-1:0] sel_i,
  output logic                        wrap_o
);
  import ptmr_pkg::*;

  logic [POST_W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned BASE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             match_o,
  output logic             irq_o
);
  import ptmr_pkg::*;

  localparam int unsigned CTL_W = $bits(ctl_t);

  logic [CNT_W-1:0] cnt_q, per_q;
  ctl_t             ctl_q;
  logic             flag_q, match_q;
  logic             wr_cnt, wr_per, wr_ctl, wr_flg;
  logic             tick, hit, chain_clr, post_wrap;

  assign wr_cnt    = wr_en_i && (addr_i == REG_CNT);
  assign wr_per    = wr_en_i && (addr_i == REG_PER);
  assign wr_ctl    = wr_en_i && (addr_i == REG_CTL);
  assign wr_flg    = wr_en_i && (addr_i == REG_FLG);
  assign chain_clr = wr_cnt || wr_ctl;

  ptmr_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl_q.run),
    .clr_i  (chain_clr),
    .sel_i  (ctl_q.pre_sel),
    .tick_o (tick)
  );

  assign hit = tick && (cnt_q == per_q);

  ptmr_postscaler u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chain_clr),
    .step_i (hit),
    .sel_i  (ctl_q.post_sel),
    .wrap_o (post_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata_i;
    else if (hit)    cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     per_q <= '1;
    else if (wr_per) per_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (post_wrap)                  flag_q <= 1'b1;
      else if (wr_flg && wdata_i[0])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CNT: rdata_o = cnt_q;
      REG_PER: rdata_o = per_q;
      REG_CTL: rdata_o = CNT_W'(ctl_q);
      default: rdata_o = CNT_W'(flag_q);
    endcase
  end

  assign match_o = match_q;
  assign irq_o   = flag_q;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             match_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_i
);
  import ptmr_pkg::*;

  // R4
  match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (cnt_q == '0));

  // R5
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> match_o);

  // R6
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_FLG && wdata_i[0]) |=> (!irq_o || match_o));

  // R8
  ctl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CTL) |=> (cnt_q == $past(cnt_q)));

  // R9
  cnt_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CNT) |=> (cnt_q == $past(wdata_i) && !match_o));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !(wr_en_i && addr_i == REG_CNT)) |=> ($stable(cnt_q) && !match_o));

  // R2
  ctl_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTL) |-> (rdata_o[7] == 1'b0));
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .match_o (match_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .run_i   (ctl_q.run)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       match_o, irq_o;

  ptmr_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .match_o(match_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit mon_on = 1'b0;
  bit irq_prev = 1'b0;

  typedef struct {bit is_irq; int at; string req;} exp_t;
  exp_t expq[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit is_irq, input int at, input string req);
    exp_t e;
    e.is_irq = is_irq; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (match_o) begin
        if (expq.size() == 0 || expq[0].is_irq)
          chk(1'b0, "R4", "unexpected match at cycle", cyc, -1);
        else begin
          chk(expq[0].at == cyc, expq[0].req, "match cycle", cyc, expq[0].at);
          void'(expq.pop_front());
        end
      end
      if (irq_o && !irq_prev) begin
        if (expq.size() == 0 || !expq[0].is_irq)
          chk(1'b0, "R5", "unexpected flag rise at cycle", cyc, -1);
        else begin
          chk(expq[0].at == cyc, expq[0].req, "flag rise cycle", cyc, expq[0].at);
          void'(expq.pop_front());
        end
      end
      irq_prev = irq_o;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1;
    e = cyc;
    wr_en_i = 1'b0;
  endtask

  task automatic rd_at(input logic [1:0] a, input int t, output logic [7:0] d);
    while (cyc < t) begin
      @(posedge clk_i);
      #1;
    end
    @(negedge clk_i);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic setup(input logic [7:0] per, input logic [7:0] ctl, output int c0);
    int e;
    wr(2'd1, per, e);
    wr(2'd0, 8'h00, e);
    wr(2'd3, 8'h01, e);
    wr(2'd2, ctl, c0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "WDOG", "watchdog expired at cycle", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int e, c0, w, v, u;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;

    // R1 reset state
    rd_at(2'd0, 0, d); chk(d == 8'h00, "R1", "count reset", d, 8'h00);
    rd_at(2'd1, 0, d); chk(d == 8'hFF, "R1", "period reset", d, 8'hFF);
    rd_at(2'd2, 0, d); chk(d == 8'h00, "R1", "control reset", d, 8'h00);
    rd_at(2'd3, 0, d); chk(d == 8'h00, "R1", "flag reset", d, 8'h00);
    chk(!irq_o && !match_o, "R1", "irq/match reset", {irq_o, match_o}, 0);

    // R2 readback and control bit 7
    wr(2'd2, 8'hFF, e);
    rd_at(2'd2, 0, d); chk(d == 8'h7F, "R2", "control readback", d, 8'h7F);
    wr(2'd2, 8'h00, e);
    rd_at(2'd2, 0, d); chk(d == 8'h00, "R2", "control cleared", d, 8'h00);
    wr(2'd1, 8'hA5, e);
    rd_at(2'd1, 0, d); chk(d == 8'hA5, "R2", "period readback", d, 8'hA5);
    wr(2'd0, 8'h3C, e);
    rd_at(2'd0, 0, d); chk(d == 8'h3C, "R2", "count readback", d, 8'h3C);

    // R3/R4/R5: P=3, prescale 1, postscale 1:2 -> 16 cycles per match
    setup(8'd3, 8'h0C, c0);
    push(1'b0, c0 + 16, "R3");
    push(1'b0, c0 + 32, "R4");
    push(1'b1, c0 + 32, "R5");
    push(1'b0, c0 + 48, "R4");
    wait_to(c0 + 52);
    wr(2'd2, 8'h00, e);
    rd_at(2'd3, 0, d); chk(d == 8'h01, "R5", "flag set", d, 1);
    // R6 write-one-to-clear
    wr(2'd3, 8'h01, e);
    rd_at(2'd3, 0, d); chk(d == 8'h00, "R6", "flag cleared", d, 0);
    chk(!irq_o, "R6", "irq_o low after clear", irq_o, 0);

    // R3: prescale 01 (x4), P=1 -> 32 cycles per match
    setup(8'd1, 8'h05, c0);
    push(1'b0, c0 + 32, "R3");
    push(1'b1, c0 + 32, "R5");
    push(1'b0, c0 + 64, "R3");
    wait_to(c0 + 70);
    wr(2'd2, 8'h00, e);

    // R3/R4: prescale 10 (don't-care bit), P=0 -> 64 cycles per match
    setup(8'd0, 8'h06, c0);
    push(1'b0, c0 + 64, "R3");
    push(1'b1, c0 + 64, "R5");
    push(1'b0, c0 + 128, "R4");
    wait_to(c0 + 130);
    wr(2'd2, 8'h00, e);

    // R7/R9: count write mid-run restarts chain and postscaler
    setup(8'd7, 8'h0C, c0);
    push(1'b0, c0 + 32, "R4");
    wait_to(c0 + 40);
    wr(2'd0, 8'd5, w);
    rd_at(2'd0, 0, d); chk(d == 8'd5, "R9", "count write visible", d, 5);
    push(1'b0, w + 12, "R9");
    push(1'b0, w + 44, "R7");
    push(1'b1, w + 44, "R7");
    wait_to(w + 50);
    wr(2'd2, 8'h00, e);
    wr(2'd3, 8'h01, e);

    // R8/R7: control write keeps count, restarts prescale
    setup(8'd200, 8'h04, c0);
    rd_at(2'd0, c0 + 41, d); chk(d == 8'd10, "R3", "count after 41 cycles", d, 10);
    wr(2'd2, 8'h04, w);
    v = (w - 1 - c0) / 4;
    rd_at(2'd0, w, d);     chk(d == v[7:0], "R8", "count kept on control write", d, v);
    rd_at(2'd0, w + 3, d); chk(d == v[7:0], "R7", "no tick before restart", d, v);
    rd_at(2'd0, w + 4, d); chk(d == v[7:0] + 8'd1, "R7", "tick after restart", d, v + 1);

    // R10: disabled holds, writes still accepted
    wr(2'd2, 8'h00, e);
    rd_at(2'd0, 0, d); u = d;
    rd_at(2'd0, e + 100, d); chk(d == u[7:0], "R10", "count held while disabled", d, u);
    wr(2'd1, 8'h5A, e);
    rd_at(2'd1, 0, d); chk(d == 8'h5A, "R10", "period write while disabled", d, 8'h5A);

    repeat (4) @(negedge clk_i);
    chk(expq.size() == 0, "R4", "expected events left", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule